// File: doc/BRIEF.md
# Flash In-System-Programming Permission Guard

This block sits between software and the erase/program engine of an on-chip flash controller. It holds one 32-bit control word that carries an ISP enable, a boot-source select and four per-region update enables, plus a sticky failure flag. The word is written and read through a small register port. Writes to it only land while the system unlock input is high.

When software pulses the ISP trigger, the guard checks the operation before it reaches the flash engine. It looks at the command code, which region the destination address falls in, which region is executing (from the boot-source select), and four status inputs: secured spare region, lock mode, debugger attached and brown-out. A legal operation goes to the engine as a one-cycle start strobe with the command and address captured. An illegal operation is dropped and the failure flag is raised. The flag stays raised until software clears it by writing a one.

Top module: `isp_guard`

## Requirements
- R1: After reset the control word reads as 0x0000_0000 and the start strobe is low.
- R2: The control word is at register offset 0 with this layout: bit 0 ISP enable, bit 1 boot select (0 = executing from application ROM, 1 = from loader ROM), bit 2 spare update enable, bit 3 application update enable, bit 4 configuration update enable, bit 5 loader update enable, bit 6 failure flag. Bits 31:7 always read 0 and ignore writes. Any other offset reads 0.
- R3: Writes to bits 5:0, and a clear of bit 6, take effect only when the unlock input is high. While it is low, such writes change nothing.
- R4: Only a failed operation sets the failure flag. Writing 1 to bit 6 while unlocked clears it. Writing 0 to bit 6 leaves it unchanged. If a failure and a clearing write occur in the same cycle, the flag ends up 1.
- R5: A trigger is accepted only when ISP enable is 1 and the engine-busy input is low. A trigger that is not accepted produces no start strobe and does not set the flag.
- R6: An accepted legal operation raises the start strobe for exactly the one cycle after the trigger edge, with the command and address presented alongside it. A failing operation never raises the strobe. Command codes are: 0x0 read, 0x1 program, 0x2 page erase.
- R7: Program or erase of the application ROM fails when boot select is 0 and the application update enable is 0. Program or erase of the loader ROM fails when boot select is 1 and the loader update enable is 0. Writing the region that is not executing, and any read, are not blocked by these enables.
- R8: Program or erase of the configuration region fails while its update enable is 0. Program or erase of the spare region fails while its update enable is 0. Reads of either region pass.
- R9: Programming the spare region fails while the secured-spare input is high. A page erase of the spare region is not blocked by that input.
- R10: A page erase fails while both lock mode and debugger-attached are high. A program is not blocked by this condition.
- R11: Any program or erase fails while brown-out is high. A read still passes.
- R12: An address outside all four windows fails for every command. Any command code other than 0x0, 0x1 or 0x2 fails. The default windows are: application 0x00000–0x0FFFF, loader 0x10000–0x10FFF, spare 0x11000–0x111FF, configuration 0x12000–0x1201F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| unlocked | input | 1 | Protected registers are writable |
| isp_go | input | 1 | Single-cycle ISP trigger |
| isp_cmd | input | 4 | ISP command code |
| isp_addr | input | FA_W | ISP destination address |
| spare_secured | input | 1 | Spare region is in secured mode |
| lock_mode | input | 1 | Chip is in lock mode |
| dbg_attached | input | 1 | Debugger connected |
| brown_out | input | 1 | Brown-out detected |
| eng_busy | input | 1 | Flash engine is running an operation |
| eng_start | output | 1 | One-cycle start to the flash engine |
| eng_cmd | output | 4 | Command handed to the engine |
| eng_addr | output | FA_W | Address handed to the engine |

## Verification
The hardest case to reach from the ports is a failing trigger and a clearing register write landing on the same edge. The flag must already be set before that edge so that a cleared-then-set result can be told apart from a never-cleared one. The bench first provokes a failure. Then, on a single falling edge, it drives the unlock write with bit 6 set together with a trigger carrying an invalid code, and reads the flag right after the next rising edge. The self-region cases take a similar path: the boot select and the matching enable are reprogrammed between triggers, so both the blocked and the cross-region outcomes are seen for each executing region.

// File: rtl/isp_guard_pkg.sv
package isp_guard_pkg;

    localparam logic [3:0] CMD_READ   = 4'h0;
    localparam logic [3:0] CMD_PROG   = 4'h1;
    localparam logic [3:0] CMD_PERASE = 4'h2;

    localparam int NUM_WIN = 4;
    localparam int WIN_APP = 0;
    localparam int WIN_LDR = 1;
    localparam int WIN_SPR = 2;
    localparam int WIN_CFG = 3;

    // control bits, bit 0 is the lowest member
    typedef struct packed {
        logic ldr_upd;   // bit 5
        logic cfg_upd;   // bit 4
        logic app_upd;   // bit 3
        logic spr_upd;   // bit 2
        logic boot_ldr;  // bit 1
        logic isp_on;    // bit 0
    } ctl_t;

    typedef struct packed {
        logic bad_cmd;
        logic bad_addr;
        logic self_app;
        logic self_ldr;
        logic cfg_locked;
        logic spr_locked;
        logic spr_secure;
        logic dbg_erase;
        logic low_volt;
    } fail_t;

    function automatic logic in_win(input logic [31:0] a,
                                    input logic [31:0] base,
                                    input logic [31:0] size);
        return (a >= base) && (a < base + size);
    endfunction

    function automatic logic cmd_known(input logic [3:0] c);
        return (c == CMD_READ) || (c == CMD_PROG) || (c == CMD_PERASE);
    endfunction

endpackage

// File: rtl/isp_permit.sv
module isp_permit
    import isp_guard_pkg::*;
#(
    parameter int          FA_W     = 20,
    parameter logic [31:0] APP_BASE = 32'h0000_0000,
    parameter logic [31:0] APP_SIZE = 32'h0001_0000,
    parameter logic [31:0] LDR_BASE = 32'h0001_0000,
    parameter logic [31:0] LDR_SIZE = 32'h0000_1000,
    parameter logic [31:0] SPR_BASE = 32'h0001_1000,
    parameter logic [31:0] SPR_SIZE = 32'h0000_0200,
    parameter logic [31:0] CFG_BASE = 32'h0001_2000,
    parameter logic [31:0] CFG_SIZE = 32'h0000_0020
) (
    input  ctl_t             ctl,
    input  logic [3:0]       cmd,
    input  logic [FA_W-1:0]  addr,
    input  logic             spare_secured,
    input  logic             lock_mode,
    input  logic             dbg_attached,
    input  logic             brown_out,
    output fail_t            why,
    output logic             permit
);
    localparam logic [31:0] WBASE [NUM_WIN] = '{APP_BASE, LDR_BASE, SPR_BASE, CFG_BASE};
    localparam logic [31:0] WSIZE [NUM_WIN] = '{APP_SIZE, LDR_SIZE, SPR_SIZE, CFG_SIZE};

    logic [NUM_WIN-1:0] hit;
    logic [31:0]        a_ext;
    logic               modify;

    assign a_ext = 32'(addr);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign hit[i] = in_win(a_ext, WBASE[i], WSIZE[i]);
    end

    assign modify = (cmd == CMD_PROG) || (cmd == CMD_PERASE);

    always_comb begin
        why            = '0;
        why.bad_cmd    = !cmd_known(cmd);
        why.bad_addr   = !(|hit);
        why.self_app   = modify && hit[WIN_APP] && !ctl.boot_ldr && !ctl.app_upd;
        why.self_ldr   = modify && hit[WIN_LDR] &&  ctl.boot_ldr && !ctl.ldr_upd;
        why.cfg_locked = modify && hit[WIN_CFG] && !ctl.cfg_upd;
        why.spr_locked = modify && hit[WIN_SPR] && !ctl.spr_upd;
        why.spr_secure = (cmd == CMD_PROG) && hit[WIN_SPR] && spare_secured;
        why.dbg_erase  = (cmd == CMD_PERASE) && lock_mode && dbg_attached;
        why.low_volt   = modify && brown_out;
    end

    assign permit = ~|why;

endmodule

// File: rtl/isp_ctl_regs.sv
module isp_ctl_regs
    import isp_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  unlocked,
    input  ctl_t  wr_ctl,
    input  logic  wr_clr,
    input  logic  hw_fail,
    output ctl_t  ctl,
    output logic  fail_flag
);
    logic wr_ok;
    assign wr_ok = wr_en && unlocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            fail_flag <= 1'b0;
        end else begin
            if (wr_ok)
                ctl <= wr_ctl;
            if (hw_fail)
                fail_flag <= 1'b1;
            else if (wr_ok && wr_clr)
                fail_flag <= 1'b0;
        end
    end

    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!(wr_en && unlocked)) |-> $stable(ctl));

    // R4
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fail_flag) |-> $past(wr_en && unlocked && wr_clr && !hw_fail));

    // R4
    flag_set_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_flag) |-> $past(hw_fail));

endmodule

// File: rtl/isp_launch.sv
module isp_launch #(
    parameter int FA_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            isp_on,
    input  logic            eng_busy,
    input  logic            permit,
    input  logic [3:0]      cmd,
    input  logic [FA_W-1:0] addr,
    output logic            fail_pulse,
    output logic            eng_start,
    output logic [3:0]      eng_cmd,
    output logic [FA_W-1:0] eng_addr
);
    logic accept;
    assign accept     = go && isp_on && !eng_busy;
    assign fail_pulse = accept && !permit;

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_start <= 1'b0;
            eng_cmd   <= '0;
            eng_addr  <= '0;
        end else begin
            eng_start <= accept && permit;
            if (accept && permit) begin
                eng_cmd  <= cmd;
                eng_addr <= addr;
            end
        end
    end

    // R5
    start_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> $past(go && isp_on && !eng_busy));

    // R6
    start_needs_permit_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> $past(permit) && (eng_cmd == $past(cmd)));

endmodule

// File: rtl/isp_guard.sv
module isp_guard
    import isp_guard_pkg::*;
#(
    parameter int          REG_AW   = 4,
    parameter int          FA_W     = 20,
    parameter logic [31:0] APP_BASE = 32'h0000_0000,
    parameter logic [31:0] APP_SIZE = 32'h0001_0000,
    parameter logic [31:0] LDR_BASE = 32'h0001_0000,
    parameter logic [31:0] LDR_SIZE = 32'h0000_1000,
    parameter logic [31:0] SPR_BASE = 32'h0001_1000,
    parameter logic [31:0] SPR_SIZE = 32'h0000_0200,
    parameter logic [31:0] CFG_BASE = 32'h0001_2000,
    parameter logic [31:0] CFG_SIZE = 32'h0000_0020
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              unlocked,
    input  logic              isp_go,
    input  logic [3:0]        isp_cmd,
    input  logic [FA_W-1:0]   isp_addr,
    input  logic              spare_secured,
    input  logic              lock_mode,
    input  logic              dbg_attached,
    input  logic              brown_out,
    input  logic              eng_busy,
    output logic              eng_start,
    output logic [3:0]        eng_cmd,
    output logic [FA_W-1:0]   eng_addr
);
    localparam int CTL_W   = $bits(ctl_t);
    localparam int FLAG_B  = CTL_W;
    localparam int RSVD_W  = 32 - CTL_W - 1;

    ctl_t  ctl;
    fail_t why;
    logic  sel, permit, fail_pulse, fail_flag;
    logic  unused_wdata_hi;

    assign sel             = (reg_addr == '0);
    assign unused_wdata_hi = ^reg_wdata[31:FLAG_B+1];

    isp_ctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr && sel),
        .unlocked  (unlocked),
        .wr_ctl    (ctl_t'(reg_wdata[CTL_W-1:0])),
        .wr_clr    (reg_wdata[FLAG_B]),
        .hw_fail   (fail_pulse),
        .ctl       (ctl),
        .fail_flag (fail_flag)
    );

    isp_permit #(
        .FA_W(FA_W),
        .APP_BASE(APP_BASE), .APP_SIZE(APP_SIZE),
        .LDR_BASE(LDR_BASE), .LDR_SIZE(LDR_SIZE),
        .SPR_BASE(SPR_BASE), .SPR_SIZE(SPR_SIZE),
        .CFG_BASE(CFG_BASE), .CFG_SIZE(CFG_SIZE)
    ) u_permit (
        .ctl           (ctl),
        .cmd           (isp_cmd),
        .addr          (isp_addr),
        .spare_secured (spare_secured),
        .lock_mode     (lock_mode),
        .dbg_attached  (dbg_attached),
        .brown_out     (brown_out),
        .why           (why),
        .permit        (permit)
    );

    isp_launch #(.FA_W(FA_W)) u_launch (
        .clk        (clk),
        .rst        (rst),
        .go         (isp_go),
        .isp_on     (ctl.isp_on),
        .eng_busy   (eng_busy),
        .permit     (permit),
        .cmd        (isp_cmd),
        .addr       (isp_addr),
        .fail_pulse (fail_pulse),
        .eng_start  (eng_start),
        .eng_cmd    (eng_cmd),
        .eng_addr   (eng_addr)
    );

    assign reg_rdata = sel ? {{RSVD_W{1'b0}}, fail_flag, ctl} : 32'h0;

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[31:FLAG_B+1] == '0);

    // R6
    fail_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_flag) |-> !eng_start);

    // R5
    idle_trigger_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_flag) |-> $past(isp_go && ctl.isp_on && !eng_busy && (why != '0)));

endmodule

// File: tb/sim_isp_guard.sv
module sim_isp_guard;
    localparam time CLK_P = 10ns;
    localparam int  FA_W  = 20;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            unlocked = 1'b1;
    logic            isp_go = 1'b0;
    logic [3:0]      isp_cmd = '0;
    logic [FA_W-1:0] isp_addr = '0;
    logic            spare_secured = 1'b0;
    logic            lock_mode = 1'b0;
    logic            dbg_attached = 1'b0;
    logic            brown_out = 1'b0;
    logic            eng_busy = 1'b0;
    logic            eng_start;
    logic [3:0]      eng_cmd;
    logic [FA_W-1:0] eng_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] cur_cfg = '0;

    always #(CLK_P/2) clk = ~clk;

    isp_guard u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .unlocked(unlocked),
        .isp_go(isp_go), .isp_cmd(isp_cmd), .isp_addr(isp_addr),
        .spare_secured(spare_secured), .lock_mode(lock_mode),
        .dbg_attached(dbg_attached), .brown_out(brown_out),
        .eng_busy(eng_busy), .eng_start(eng_start), .eng_cmd(eng_cmd),
        .eng_addr(eng_addr)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // program enables (bits 5:0) and clear the flag
    task automatic cfg(input logic [5:0] c);
        cur_cfg = c;
        reg_write({25'h0, 1'b1, c});
    endtask

    task automatic fire(input logic [3:0] c, input logic [FA_W-1:0] a,
                        input logic exp_pass, input string tag);
        cfg(cur_cfg);
        @(negedge clk);
        isp_go = 1'b1; isp_cmd = c; isp_addr = a;
        @(posedge clk); #1;
        check({31'h0, eng_start}, {31'h0, exp_pass}, {tag, " start"});
        check({31'h0, reg_rdata[6]}, {31'h0, !exp_pass}, {tag, " flag"});
        if (exp_pass) begin
            check({28'h0, eng_cmd}, {28'h0, c}, {tag, " cmd"});
            check(32'(eng_addr), 32'(a), {tag, " addr"});
        end
        @(negedge clk);
        isp_go = 1'b0;
        @(posedge clk); #1;
        check({31'h0, eng_start}, 32'h0, {tag, " start one cycle R6"});
    endtask

    task automatic t_reset;
        check(reg_rdata, 32'h0, "R1 reset word");
        check({31'h0, eng_start}, 32'h0, "R1 reset start");
    endtask

    task automatic t_layout;
        reg_write(32'hFFFF_FFFF);
        check(reg_rdata, 32'h0000_003F, "R2 reserved masked");
        @(negedge clk); reg_addr = 4'h1;
        #1 check(reg_rdata, 32'h0, "R2 other offset");
        reg_addr = 4'h0;
        reg_write(32'h0);
        check(reg_rdata, 32'h0, "R2 cleared");
    endtask

    task automatic t_unlock;
        unlocked = 1'b0;
        reg_write(32'h0000_003F);
        check(reg_rdata, 32'h0, "R3 locked write ignored");
        unlocked = 1'b1;
        cur_cfg = 6'h01;
        reg_write(32'h1);
        @(negedge clk); isp_go = 1'b1; isp_cmd = 4'h7; isp_addr = '0;
        @(negedge clk); isp_go = 1'b0;
        check({31'h0, reg_rdata[6]}, 32'h1, "R4 fail sets flag");
        reg_write(32'h0000_0001);
        check({31'h0, reg_rdata[6]}, 32'h1, "R4 write 0 keeps flag");
        unlocked = 1'b0;
        reg_write(32'h0000_0041);
        check({31'h0, reg_rdata[6]}, 32'h1, "R3 locked clear ignored");
        unlocked = 1'b1;
        reg_write(32'h0000_0041);
        check(reg_rdata, 32'h1, "R4 write 1 clears");
    endtask

    task automatic t_trigger_gate;
        cfg(6'h00);
        @(negedge clk); isp_go = 1'b1; isp_cmd = 4'hF;
        @(posedge clk); #1;
        check({31'h0, eng_start}, 32'h0, "R5 disabled no start");
        check({31'h0, reg_rdata[6]}, 32'h0, "R5 disabled no flag");
        @(negedge clk); isp_go = 1'b0;
        cfg(6'h01);
        @(negedge clk); eng_busy = 1'b1; isp_go = 1'b1; isp_cmd = 4'h0; isp_addr = 20'h00100;
        @(posedge clk); #1;
        check({31'h0, eng_start}, 32'h0, "R5 busy no start");
        @(negedge clk); isp_go = 1'b0; eng_busy = 1'b0;
    endtask

    task automatic t_self;
        cfg(6'h01);
        fire(4'h0, 20'h00100, 1'b1, "R6 read passes");
        fire(4'h1, 20'h00200, 1'b0, "R7 app self write blocked");
        cfg(6'h09);
        fire(4'h1, 20'h00200, 1'b1, "R7 app self write enabled");
        fire(4'h2, 20'h10000, 1'b1, "R7 cross to loader");
        cfg(6'h03);
        fire(4'h1, 20'h10010, 1'b0, "R7 loader self write blocked");
        fire(4'h1, 20'h00040, 1'b1, "R7 cross to app");
        cfg(6'h23);
        fire(4'h2, 20'h10FFF, 1'b1, "R7 loader self enabled");
    endtask

    task automatic t_cfg_spare;
        cfg(6'h01);
        fire(4'h2, 20'h12000, 1'b0, "R8 config erase blocked");
        fire(4'h0, 20'h1201F, 1'b1, "R8 config read passes");
        fire(4'h1, 20'h11000, 1'b0, "R8 spare program blocked");
        cfg(6'h15);
        fire(4'h2, 20'h12000, 1'b1, "R8 config erase enabled");
        fire(4'h1, 20'h111FF, 1'b1, "R8 spare program enabled");
        spare_secured = 1'b1;
        fire(4'h1, 20'h11004, 1'b0, "R9 secured spare program");
        fire(4'h2, 20'h11000, 1'b1, "R9 secured spare erase");
        spare_secured = 1'b0;
    endtask

    task automatic t_status;
        cfg(6'h09);
        lock_mode = 1'b1; dbg_attached = 1'b1;
        fire(4'h2, 20'h00400, 1'b0, "R10 erase lock+debug");
        fire(4'h1, 20'h00400, 1'b1, "R10 program lock+debug");
        dbg_attached = 1'b0;
        fire(4'h2, 20'h00400, 1'b1, "R10 erase lock only");
        lock_mode = 1'b0;
        brown_out = 1'b1;
        fire(4'h1, 20'h00400, 1'b0, "R11 program brown-out");
        fire(4'h2, 20'h10000, 1'b0, "R11 erase brown-out");
        fire(4'h0, 20'h00400, 1'b1, "R11 read brown-out");
        brown_out = 1'b0;
    endtask

    task automatic t_legal;
        cfg(6'h3D);
        fire(4'h0, 20'h13000, 1'b0, "R12 address outside");
        fire(4'h0, 20'h11200, 1'b0, "R12 gap address");
        fire(4'h3, 20'h00000, 1'b0, "R12 code 0x3");
        fire(4'hF, 20'h00000, 1'b0, "R12 code 0xF");
        fire(4'h0, 20'h0FFFF, 1'b1, "R12 app top edge");
    endtask

    task automatic t_set_wins;
        cfg(6'h01);
        @(negedge clk); isp_go = 1'b1; isp_cmd = 4'h9;
        @(negedge clk); isp_go = 1'b0;
        check({31'h0, reg_rdata[6]}, 32'h1, "R4 preset flag");
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h41; isp_go = 1'b1; isp_cmd = 4'h9;
        @(posedge clk); #1;
        check({31'h0, reg_rdata[6]}, 32'h1, "R4 set wins over clear");
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; isp_go = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 t_reset();
        t_layout();
        t_unlock();
        t_trigger_gate();
        t_self();
        t_cfg_spare();
        t_status();
        t_legal();
        t_set_wins();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule